// File: doc/BRIEF.md
# Memory Responder Fault Injector

This block sits on the response side of a memory responder that stores an ECC codeword with each write. Software programs two 32-bit registers: a control register that sets the injection mode and a repeat count, and a selection register that picks which faults to apply. Four fault types can be selected: a single-bit ECC fault, a double-bit ECC fault, inversion of either bit of the write-response code, and inversion of either bit of the read-response code. Once armed, the block corrupts the selected items on the next transfer, or on a programmed run of consecutive transfers. It then drops back to idle and clears the mode field, so software can poll for completion.

The control flow is a three-state machine. `ST_IDLE` passes every input straight through. `ST_ONCE` applies the faults until one counted transfer completes. `ST_RUN` applies them until count+1 counted transfers complete. The transitions are as follows:
- A control write with mode 01 goes to `ST_ONCE`.
- A control write with mode 1x goes to `ST_RUN`.
- A control write with mode 00 goes to `ST_IDLE`.
- A counted transfer in `ST_ONCE`, or the last counted transfer in `ST_RUN`, goes to `ST_IDLE`.
- A control write in any state overrides the transfer-driven transition.

One instance serves one pseudo-channel. The control and selection addresses are parameters: 0x600/0x604 for channel 0, and 0x900/0x904 for a second instance serving channel 1.

Top module: `mem_resp_err_inj`

## Requirements
- R1: After reset both registers read as zero and every output equals its matching input.
- R2: The control register reads mode in bits [1:0] and count in bits [4:2]. The selection register reads only bits 0, 1, 17, 18, 25 and 26. All other bits read as zero whatever was written.
- R3: With mode 00, no fault is applied on any transfer, whatever the selection.
- R4: Mode 01 corrupts exactly one counted transfer. After that transfer the mode field reads 00 and the count field keeps its value.
- R5: Mode 10 or 11 corrupts count+1 counted transfers (count 0 gives one, count 7 gives eight). Then the mode field reads 00.
- R6: While active, selection bit 0 inverts ECC bit 0 and selection bit 1 inverts ECC bits 0 and 1. With both bits set, only the two-bit pattern is applied.
- R7: While active, selection bits 17 and 18 invert write-response bits 0 and 1.
- R8: While active, selection bits 25 and 26 invert read-response bits 0 and 1.
- R9: A transfer is counted only when valid and ready are both high on a channel that has a selected fault. If nothing is selected, any handshake counts. A stalled beat shows the corruption but does not use up the run.
- R10: A control write during a run restarts it with the new mode and count. Writing mode 00 cancels it at once.
- R11: Writes to any address other than the two register addresses change nothing, and reads there return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_rd_en | input | 1 | Register read strobe |
| reg_addr | input | ADDR_W | Byte address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, same cycle as reg_rd_en |
| wr_valid | input | 1 | Write data beat valid |
| wr_ready | input | 1 | Write data beat accepted |
| ecc_in | input | ECC_W | Generated ECC codeword |
| ecc_out | output | ECC_W | Codeword to store |
| bresp_valid | input | 1 | Write response valid |
| bresp_ready | input | 1 | Write response accepted |
| bresp_in | input | 2 | Write response code |
| bresp_out | output | 2 | Write response code after faults |
| rdat_valid | input | 1 | Read data beat valid |
| rdat_ready | input | 1 | Read data beat accepted |
| rresp_in | input | 2 | Read response code |
| rresp_out | output | 2 | Read response code after faults |

## Verification
The bench attacks the run length at both ends of the count field. A design with an off-by-one would corrupt one transfer too many or too few. It stalls beats with ready low; a design that counted valid alone would end a run early. It selects only one channel's fault and then sends traffic on other channels; a design counting every handshake would finish before the selected channel saw a fault. It also sets both ECC selections to catch three-bit or one-bit patterns, rewrites the control register mid-run to check the restart, and cancels with mode 00. Random runs mix all three channels against a bench model of the remaining count.

// File: rtl/mri_pkg.sv
package mri_pkg;
    localparam int REG_W = 32;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ONCE = 2'd1,
        ST_RUN  = 2'd2
    } inj_state_t;

    localparam int SEL_SBE = 0;
    localparam int SEL_DBE = 1;
    localparam int SEL_B0  = 17;
    localparam int SEL_B1  = 18;
    localparam int SEL_R0  = 25;
    localparam int SEL_R1  = 26;

    typedef struct packed {
        logic       sbe;
        logic       dbe;
        logic [1:0] bflip;
        logic [1:0] rflip;
    } fault_sel_t;
endpackage

// File: rtl/mri_regs.sv
module mri_regs
    import mri_pkg::*;
#(
    parameter int                ADDR_W    = 12,
    parameter int                CNT_W     = 3,
    parameter logic [ADDR_W-1:0] CTRL_ADDR = 12'h600,
    parameter logic [ADDR_W-1:0] SEL_ADDR  = 12'h604
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [REG_W-1:0]  wdata,
    output logic [REG_W-1:0]  rdata,
    input  logic              hw_clear,
    output logic              ctrl_wr,
    output logic [1:0]        new_mode,
    output logic [CNT_W-1:0]  new_cnt,
    output fault_sel_t        sel
);
    logic [1:0]       mode_q;
    logic [CNT_W-1:0] cnt_q;
    logic             sel_wr;

    assign ctrl_wr  = wr_en && (addr == CTRL_ADDR);
    assign sel_wr   = wr_en && (addr == SEL_ADDR);
    assign new_mode = wdata[1:0];
    assign new_cnt  = wdata[2 +: CNT_W];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= 2'b00;
            cnt_q  <= '0;
        end else if (ctrl_wr) begin
            mode_q <= new_mode;
            cnt_q  <= new_cnt;
        end else if (hw_clear) begin
            mode_q <= 2'b00;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel <= '0;
        end else if (sel_wr) begin
            sel.sbe   <= wdata[SEL_SBE];
            sel.dbe   <= wdata[SEL_DBE];
            sel.bflip <= {wdata[SEL_B1], wdata[SEL_B0]};
            sel.rflip <= {wdata[SEL_R1], wdata[SEL_R0]};
        end
    end

    always_comb begin
        rdata = '0;
        if (rd_en) begin
            if (addr == CTRL_ADDR) begin
                rdata[1:0]       = mode_q;
                rdata[2 +: CNT_W] = cnt_q;
            end else if (addr == SEL_ADDR) begin
                rdata[SEL_SBE] = sel.sbe;
                rdata[SEL_DBE] = sel.dbe;
                rdata[SEL_B0]  = sel.bflip[0];
                rdata[SEL_B1]  = sel.bflip[1];
                rdata[SEL_R0]  = sel.rflip[0];
                rdata[SEL_R1]  = sel.rflip[1];
            end
        end
    end
endmodule

// File: rtl/mri_fsm.sv
module mri_fsm
    import mri_pkg::*;
#(
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctrl_wr,
    input  logic [1:0]       new_mode,
    input  logic [CNT_W-1:0] new_cnt,
    input  logic             xfer,
    output logic             active,
    output logic             done,
    output inj_state_t       state,
    output logic [CNT_W-1:0] remain
);
    inj_state_t       state_d;
    logic [CNT_W-1:0] remain_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            remain <= '0;
        end else begin
            state  <= state_d;
            remain <= remain_d;
        end
    end

    always_comb begin
        state_d  = state;
        remain_d = remain;
        done     = 1'b0;
        active   = (state != ST_IDLE);
        if (ctrl_wr) begin
            remain_d = new_cnt;
            if (new_mode == 2'b00)   state_d = ST_IDLE;
            else if (new_mode[1])    state_d = ST_RUN;
            else                     state_d = ST_ONCE;
        end else begin
            unique case (state)
                ST_IDLE: ;
                ST_ONCE: begin
                    if (xfer) begin
                        state_d = ST_IDLE;
                        done    = 1'b1;
                    end
                end
                ST_RUN: begin
                    if (xfer) begin
                        if (remain == '0) begin
                            state_d = ST_IDLE;
                            done    = 1'b1;
                        end else begin
                            remain_d = remain - 1'b1;
                        end
                    end
                end
                default: state_d = ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/mri_corrupt.sv
module mri_corrupt
    import mri_pkg::*;
#(
    parameter int ECC_W = 8
) (
    input  logic             active,
    input  fault_sel_t       sel,
    input  logic [ECC_W-1:0] ecc_in,
    input  logic [1:0]       bresp_in,
    input  logic [1:0]       rresp_in,
    output logic [ECC_W-1:0] ecc_out,
    output logic [1:0]       bresp_out,
    output logic [1:0]       rresp_out
);
    logic [ECC_W-1:0] ecc_mask;

    always_comb begin
        ecc_mask = '0;
        if (active) begin
            if (sel.dbe)      ecc_mask[1:0] = 2'b11;
            else if (sel.sbe) ecc_mask[0]   = 1'b1;
        end
    end

    assign ecc_out   = ecc_in ^ ecc_mask;
    assign bresp_out = bresp_in ^ (active ? sel.bflip : 2'b00);
    assign rresp_out = rresp_in ^ (active ? sel.rflip : 2'b00);
endmodule

// File: rtl/mem_resp_err_inj.sv
module mem_resp_err_inj
    import mri_pkg::*;
#(
    parameter int                ADDR_W    = 12,
    parameter int                ECC_W     = 8,
    parameter int                CNT_W     = 3,
    parameter logic [ADDR_W-1:0] CTRL_ADDR = 12'h600,
    parameter logic [ADDR_W-1:0] SEL_ADDR  = 12'h604
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr_en,
    input  logic              reg_rd_en,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              wr_valid,
    input  logic              wr_ready,
    input  logic [ECC_W-1:0]  ecc_in,
    output logic [ECC_W-1:0]  ecc_out,
    input  logic              bresp_valid,
    input  logic              bresp_ready,
    input  logic [1:0]        bresp_in,
    output logic [1:0]        bresp_out,
    input  logic              rdat_valid,
    input  logic              rdat_ready,
    input  logic [1:0]        rresp_in,
    output logic [1:0]        rresp_out
);
    logic             ctrl_wr;
    logic [1:0]       new_mode;
    logic [CNT_W-1:0] new_cnt;
    fault_sel_t       sel;
    logic             active;
    logic             done;
    inj_state_t       state;
    logic [CNT_W-1:0] remain;
    logic             xfer;
    logic             wr_hs, b_hs, r_hs;
    logic             use_ecc, use_b, use_r, use_none;

    assign wr_hs    = wr_valid && wr_ready;
    assign b_hs     = bresp_valid && bresp_ready;
    assign r_hs     = rdat_valid && rdat_ready;
    assign use_ecc  = sel.sbe || sel.dbe;
    assign use_b    = |sel.bflip;
    assign use_r    = |sel.rflip;
    assign use_none = !(use_ecc || use_b || use_r);
    assign xfer     = (wr_hs && use_ecc) || (b_hs && use_b) || (r_hs && use_r)
                    || (use_none && (wr_hs || b_hs || r_hs));

    mri_regs #(
        .ADDR_W(ADDR_W), .CNT_W(CNT_W),
        .CTRL_ADDR(CTRL_ADDR), .SEL_ADDR(SEL_ADDR)
    ) u_regs (
        .clk(clk), .rst_n(rst_n),
        .wr_en(reg_wr_en), .rd_en(reg_rd_en), .addr(reg_addr),
        .wdata(reg_wdata), .rdata(reg_rdata),
        .hw_clear(done), .ctrl_wr(ctrl_wr),
        .new_mode(new_mode), .new_cnt(new_cnt), .sel(sel)
    );

    mri_fsm #(.CNT_W(CNT_W)) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .ctrl_wr(ctrl_wr), .new_mode(new_mode), .new_cnt(new_cnt),
        .xfer(xfer), .active(active), .done(done),
        .state(state), .remain(remain)
    );

    mri_corrupt #(.ECC_W(ECC_W)) u_corrupt (
        .active(active), .sel(sel),
        .ecc_in(ecc_in), .bresp_in(bresp_in), .rresp_in(rresp_in),
        .ecc_out(ecc_out), .bresp_out(bresp_out), .rresp_out(rresp_out)
    );
endmodule

// File: rtl/mri_checker.sv
module mri_checker
    import mri_pkg::*;
#(
    parameter int                ADDR_W    = 12,
    parameter int                ECC_W     = 8,
    parameter int                CNT_W     = 3,
    parameter logic [ADDR_W-1:0] CTRL_ADDR = 12'h600
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_rd_en,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [31:0]       reg_rdata,
    input logic              ctrl_wr,
    input logic              xfer,
    input inj_state_t        state,
    input logic [CNT_W-1:0]  remain,
    input fault_sel_t        sel,
    input logic [ECC_W-1:0]  ecc_in,
    input logic [ECC_W-1:0]  ecc_out,
    input logic [1:0]        bresp_in,
    input logic [1:0]        bresp_out,
    input logic [1:0]        rresp_in,
    input logic [1:0]        rresp_out
);
    // R1 / R3: idle means pass-through everywhere
    p_idle_clean_r3: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_IDLE |-> (ecc_out == ecc_in && bresp_out == bresp_in
                              && rresp_out == rresp_in));

    // R2: reserved control bits read zero
    p_ctrl_reserved_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd_en && reg_addr == CTRL_ADDR) |-> reg_rdata[31:2+CNT_W] == '0);

    // R4: one counted transfer ends a single shot
    p_once_ends_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ONCE && xfer && !ctrl_wr) |=> state == ST_IDLE);

    // R5: each counted transfer in a run steps the remaining count down
    p_run_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN && xfer && !ctrl_wr && remain != '0)
        |=> (state == ST_RUN && remain == $past(remain) - 1'b1));

    // R6: double pattern wins over single
    p_dbe_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE && sel.dbe) |-> ((ecc_out ^ ecc_in) == ECC_W'(3)));

    // R9: no counted transfer, no progress
    p_stall_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE && !xfer && !ctrl_wr)
        |=> (state == $past(state) && $stable(remain)));
endmodule

bind mem_resp_err_inj mri_checker #(
    .ADDR_W(ADDR_W), .ECC_W(ECC_W), .CNT_W(CNT_W), .CTRL_ADDR(CTRL_ADDR)
) u_chk (
    .clk(clk), .rst_n(rst_n),
    .reg_rd_en(reg_rd_en), .reg_addr(reg_addr), .reg_rdata(reg_rdata),
    .ctrl_wr(ctrl_wr), .xfer(xfer), .state(state), .remain(remain),
    .sel(sel), .ecc_in(ecc_in), .ecc_out(ecc_out),
    .bresp_in(bresp_in), .bresp_out(bresp_out),
    .rresp_in(rresp_in), .rresp_out(rresp_out)
);

// File: tb/mem_resp_err_inj_test.sv
module mem_resp_err_inj_test;
    localparam logic [11:0] A_CTRL = 12'h600;
    localparam logic [11:0] A_SEL  = 12'h604;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic reg_wr_en = 0, reg_rd_en = 0;
    logic [11:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0, reg_rdata;
    logic wr_valid = 0, wr_ready = 0, bresp_valid = 0, bresp_ready = 0;
    logic rdat_valid = 0, rdat_ready = 0;
    logic [7:0] ecc_in = '0, ecc_out;
    logic [1:0] bresp_in = '0, bresp_out, rresp_in = '0, rresp_out;

    int nchk = 0, nbad = 0;
    bit ended = 0;

    // bench model of the programmed state
    bit m_sbe, m_dbe;
    bit [1:0] m_bf, m_rf;
    bit m_act;
    int m_rem;
    bit [1:0] m_mode;
    bit [2:0] m_cnt;

    always #4 clk = ~clk;

    mem_resp_err_inj uut (
        .clk(clk), .rst_n(rst_n),
        .reg_wr_en(reg_wr_en), .reg_rd_en(reg_rd_en), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .wr_valid(wr_valid), .wr_ready(wr_ready), .ecc_in(ecc_in), .ecc_out(ecc_out),
        .bresp_valid(bresp_valid), .bresp_ready(bresp_ready),
        .bresp_in(bresp_in), .bresp_out(bresp_out),
        .rdat_valid(rdat_valid), .rdat_ready(rdat_ready),
        .rresp_in(rresp_in), .rresp_out(rresp_out)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nbad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_ecc(input logic [7:0] v);
        if (!m_act) return v;
        if (m_dbe) return v ^ 8'h03;
        if (m_sbe) return v ^ 8'h01;
        return v;
    endfunction

    function automatic bit counts(input int ch);
        bit none = !(m_sbe || m_dbe || m_bf != 0 || m_rf != 0);
        if (none) return 1'b1;
        if (ch == 0) return m_sbe || m_dbe;
        if (ch == 1) return m_bf != 0;
        return m_rf != 0;
    endfunction

    task automatic idle_bus();
        wr_valid = 0; wr_ready = 0; bresp_valid = 0; bresp_ready = 0;
        rdat_valid = 0; rdat_ready = 0;
    endtask

    task automatic reg_wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        idle_bus();
        reg_addr = a; reg_wdata = d; reg_wr_en = 1;
        @(posedge clk);
        #1 reg_wr_en = 0;
        if (a == A_CTRL) begin
            m_mode = d[1:0]; m_cnt = d[4:2];
            m_act  = d[1:0] != 2'b00;
            m_rem  = d[1] ? int'(d[4:2]) + 1 : 1;
        end else if (a == A_SEL) begin
            m_sbe = d[0]; m_dbe = d[1];
            m_bf = {d[18], d[17]}; m_rf = {d[26], d[25]};
        end
    endtask

    task automatic reg_rd(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        idle_bus();
        reg_addr = a; reg_rd_en = 1;
        #1 d = reg_rdata;
        reg_rd_en = 0;
    endtask

    // one beat on channel ch (0 write data, 1 write resp, 2 read data)
    task automatic beat(input int ch, input bit rdy, input string tag);
        @(negedge clk);
        idle_bus();
        ecc_in = 8'($urandom); bresp_in = 2'($urandom); rresp_in = 2'($urandom);
        case (ch)
            0: begin wr_valid = 1; wr_ready = rdy; end
            1: begin bresp_valid = 1; bresp_ready = rdy; end
            default: begin rdat_valid = 1; rdat_ready = rdy; end
        endcase
        #1;
        case (ch)
            0: chk(tag, 32'(ecc_out), 32'(exp_ecc(ecc_in)));
            1: chk(tag, 32'(bresp_out), 32'(bresp_in ^ (m_act ? m_bf : 2'b00)));
            default: chk(tag, 32'(rresp_out), 32'(rresp_in ^ (m_act ? m_rf : 2'b00)));
        endcase
        @(posedge clk);
        if (rdy && m_act && counts(ch)) begin
            m_rem--;
            if (m_rem == 0) begin m_act = 0; m_mode = 2'b00; end
        end
    endtask

    task automatic check_ctrl(input string tag);
        logic [31:0] d;
        reg_rd(A_CTRL, d);
        chk(tag, d, {27'b0, m_cnt, m_mode});
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1;
            $display("test done: total=%0d bad=%0d", nchk, nbad);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        nchk++; nbad++;
        $display("FAIL watchdog act=hung exp=done");
        finish_run();
    end

    initial begin
        logic [31:0] d;
        void'($urandom(32'd1234));
        m_act = 0; m_rem = 0; m_mode = 0; m_cnt = 0;
        m_sbe = 0; m_dbe = 0; m_bf = 0; m_rf = 0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1;

        // R1 reset state
        reg_rd(A_CTRL, d); chk("R1 ctrl reset", d, 0);
        reg_rd(A_SEL, d);  chk("R1 sel reset", d, 0);
        beat(0, 1, "R1 ecc pass"); beat(1, 1, "R1 b pass"); beat(2, 1, "R1 r pass");

        // R2 reserved bits
        reg_wr(A_CTRL, 32'hFFFF_FFFC);
        reg_rd(A_CTRL, d); chk("R2 ctrl readback", d, 32'h0000_001C);
        reg_wr(A_SEL, 32'hFFFF_FFFF);
        reg_rd(A_SEL, d);  chk("R2 sel readback", d, 32'h0606_0003);

        // R3 mode 00 with all faults selected
        for (int i = 0; i < 4; i++) beat(i % 3, 1, "R3 mode00 clean");

        // R11 stray addresses
        reg_wr(12'h608, 32'hFFFF_FFFF);
        reg_wr(12'h900, 32'h0000_0001);
        reg_rd(12'h608, d); chk("R11 stray read zero", d, 0);
        check_ctrl("R11 ctrl untouched");
        reg_rd(A_SEL, d);  chk("R11 sel untouched", d, 32'h0606_0003);

        // R4 + R6 + R9: single shot, sbe only, stall first
        reg_wr(A_SEL, 32'h0000_0001);
        reg_wr(A_CTRL, 32'h0000_0015);
        beat(0, 0, "R9 stalled beat shows sbe");
        beat(2, 1, "R9 read beat not counted");
        beat(0, 1, "R6 sbe on counted beat");
        beat(0, 1, "R4 clean after single shot");
        check_ctrl("R4 mode cleared count kept");

        // R6 both selected gives two-bit pattern
        reg_wr(A_SEL, 32'h0000_0003);
        reg_wr(A_CTRL, 32'h0000_0001);
        beat(0, 1, "R6 dbe priority");
        beat(0, 1, "R6 clean after");

        // R7 / R8 individual flips, burst count 0 => one transfer
        reg_wr(A_SEL, 32'h0002_0000);
        reg_wr(A_CTRL, 32'h0000_0002);
        beat(0, 1, "R9 write beat not counted for b flip");
        beat(1, 1, "R7 bresp bit0 flip");
        beat(1, 1, "R5 count0 one transfer");
        reg_wr(A_SEL, 32'h0400_0000);
        reg_wr(A_CTRL, 32'h0000_0003);
        beat(2, 1, "R8 rresp bit1 flip");
        beat(2, 1, "R8 clean after");

        // R5 count 7 => eight transfers
        reg_wr(A_SEL, 32'h0006_0000);
        reg_wr(A_CTRL, 32'h0000_001E);
        for (int i = 0; i < 10; i++) beat(1, 1, "R5 eight transfer run");
        check_ctrl("R5 mode cleared");

        // R10 restart and cancel
        reg_wr(A_SEL, 32'h0000_0002);
        reg_wr(A_CTRL, 32'h0000_001E);
        beat(0, 1, "R10 run started");
        beat(0, 1, "R10 run second");
        reg_wr(A_CTRL, 32'h0000_0006);
        for (int i = 0; i < 3; i++) beat(0, 1, "R10 restarted run of two");
        reg_wr(A_CTRL, 32'h0000_001E);
        beat(0, 1, "R10 armed");
        reg_wr(A_CTRL, 32'h0000_0000);
        beat(0, 1, "R10 cancelled clean");
        check_ctrl("R10 mode zero after cancel");

        // random runs
        for (int it = 0; it < 60; it++) begin
            logic [31:0] s;
            s = 32'($urandom) & 32'h0606_0003;
            reg_wr(A_SEL, s);
            reg_wr(A_CTRL, {27'b0, 3'($urandom), 1'b1, 1'($urandom)});
            for (int k = 0; k < 14; k++)
                beat(int'($urandom % 3), 1'($urandom % 4 != 0), "R5 random run");
            check_ctrl("R5 random mode state");
        end

        finish_run();
    end
endmodule